// File: doc/BRIEF.md
# Receive Status Watchdog Timer

This block guards the receive-status flag of a receive DMA engine. Normally the DMA raises that flag automatically when a frame finishes. A descriptor may suppress that automatic set. When a frame completes with the set suppressed, this block starts a timeout. When the timeout runs out, the block raises the flag itself, so that software is still told about the frame within a bounded time.

The timeout is held in an 8-bit count register, in units of 256 clock cycles. A value of zero turns the watchdog off. A single-cycle strobe reports each completed frame, with a companion bit saying whether the automatic flag set was suppressed. A separate input marks an automatic set of the flag. Any automatic set also cancels a pending timeout. The flag stays high until software writes a one-to-clear pulse. Reset is asynchronous and active-low, and its release is synchronised inside the block. All timing below counts from the first clock edge after the two-stage synchroniser has released.

Top module: `rx_stat_wdog`

## Requirements
- R1: After reset, the count register reads 0x00000000 and the flag output is 0.
- R2: A write stores wr_count in bits 7:0 of the register. Read bits 31:8 are always zero.
- R3: Take a frame-done strobe with the suppress bit high, seen at clock edge E, with count N nonzero. The flag stays low through edge E+N*256-1 and is high after edge E+N*256.
- R4: When the count is 0, a suppressed frame completion starts nothing, and the flag stays low.
- R5: A frame-done strobe with the suppress bit low does not start the timer.
- R6: An automatic-set pulse sets the flag at the next edge and cancels any running timeout.
- R7: A suppressed frame completion that arrives while the timer runs restarts the full N*256 delay from its own edge.
- R8: Writing 0 to the count while the timer runs stops the timer, and the flag is not set.
- R9: The flag holds until a clear pulse. A clear pulse in the same cycle as an expiry or an automatic set leaves the flag high.
- R10: After an expiry the timer is stopped. Once the flag is cleared, it stays low without a new arming event.
- R11: An automatic set and a suppressed frame completion in the same cycle do not arm the timer. The automatic set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Count register write strobe |
| wr_count | input | 8 | Count value written, in units of 256 cycles |
| rd_data | output | 32 | Count register read value; bits 31:8 are zero |
| frm_done | input | 1 | Frame transfer complete strobe |
| frm_suppr | input | 1 | 1 when the automatic flag set was suppressed for this frame |
| auto_set | input | 1 | Automatic receive-status set |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| rs_flag | output | 1 | Receive-status flag |

## Verification
Two pairs of functions can fall in the same cycle, and both are provoked on purpose.

- **Software clear against a set.** The bench drives the clear pulse on the exact edge where a timeout expires, and again on the edge of an automatic set. It then checks that the flag is still high. A lone clear must then drop the flag.
- **Cancel against arm.** The bench drives an automatic set together with a suppressed completion. It then clears the flag and waits past the longest delay that arm could have started. The flag must stay low.

Expiry edges are computed as N*256 from the arming edge, and the bench sweeps every count from 1 to 8, plus 255.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned PRE_W = 8;
  localparam int unsigned REG_W = 32;

  typedef struct packed {
    logic arm;
    logic cancel;
  } tmr_ctl_t;
endpackage

// File: rtl/rsw_rst_sync.sv
module rsw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rsw_cfg_reg.sv
module rsw_cfg_reg
  import rsw_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_count,
  output logic [CW-1:0] cnt_q,
  output logic [RW-1:0] rd_data
);
  localparam int unsigned PAD_W = RW - CW;
  logic [CW-1:0] cnt_d;

  always_comb cnt_d = wr_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= cnt_d;
  end

  assign rd_data = {{PAD_W{1'b0}}, cnt_q};
endmodule

// File: rtl/rsw_timer.sv
module rsw_timer
  import rsw_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_q,
  input  tmr_ctl_t      ctl,
  output logic          running,
  output logic          expire
);
  localparam logic [PW-1:0] PRE_LAST = {PW{1'b1}};
  localparam logic [CW-1:0] DN_ONE   = CW'(1);

  logic          run_q, run_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [CW-1:0] dn_q, dn_d;
  logic          tick, upd_en, cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign tick     = run_q && (pre_q == PRE_LAST);
  assign upd_en   = run_q | ctl.arm | ctl.cancel;

  always_comb begin
    run_d  = run_q;
    pre_d  = pre_q;
    dn_d   = dn_q;
    expire = 1'b0;
    if (ctl.cancel || cnt_zero) begin
      run_d = 1'b0;
    end else if (ctl.arm) begin
      run_d = 1'b1;
      pre_d = '0;
      dn_d  = cnt_q;
    end else if (run_q) begin
      pre_d = pre_q + PW'(1);
      if (tick) begin
        if (dn_q == DN_ONE) begin
          expire = 1'b1;
          run_d  = 1'b0;
        end else begin
          dn_d = dn_q - DN_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      dn_q  <= '0;
    end else if (upd_en) begin
      run_q <= run_d;
      pre_q <= pre_d;
      dn_q  <= dn_d;
    end
  end

  assign running = run_q;
endmodule

// File: rtl/rsw_flag.sv
module rsw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_auto,
  input  logic set_tmo,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d, flag_en;

  assign flag_en = set_auto | set_tmo | clr;

  always_comb begin
    if (set_auto || set_tmo) flag_d = 1'b1;
    else if (clr)            flag_d = 1'b0;
    else                     flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/rx_stat_wdog.sv
module rx_stat_wdog
  import rsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  output logic [REG_W-1:0] rd_data,
  input  logic             frm_done,
  input  logic             frm_suppr,
  input  logic             auto_set,
  input  logic             flag_clr,
  output logic             rs_flag
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt_q;
  logic             tmr_run;
  logic             expire;
  tmr_ctl_t         ctl;

  rsw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rsw_cfg_reg #(.CW(CNT_W), .RW(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_count(wr_count),
    .cnt_q(cnt_q), .rd_data(rd_data)
  );

  always_comb begin
    ctl.cancel = auto_set;
    ctl.arm    = frm_done & frm_suppr;
  end

  rsw_timer #(.CW(CNT_W), .PW(PRE_W)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .cnt_q(cnt_q), .ctl(ctl),
    .running(tmr_run), .expire(expire)
  );

  rsw_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .set_auto(auto_set), .set_tmo(expire),
    .clr(flag_clr), .flag(rs_flag)
  );
endmodule

// File: rtl/rsw_chk.sv
module rsw_chk
  import rsw_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic [REG_W-1:0] rd_data,
  input logic [CNT_W-1:0] cnt_q,
  input logic             frm_done,
  input logic             frm_suppr,
  input logic             auto_set,
  input logic             flag_clr,
  input logic             expire,
  input logic             tmr_run,
  input logic             rs_flag
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[REG_W-1:CNT_W] == '0);                                        // R2
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_q == '0) |=> !tmr_run);                                          // R4
  AST_AUTO_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    auto_set |=> rs_flag);                                                // R6
  AST_AUTO_CANCEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    auto_set |=> !tmr_run);                                               // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rs_flag && !flag_clr) |=> rs_flag);                                  // R9
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_clr && expire) |=> rs_flag);                                    // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_clr && !auto_set && !expire) |=> !rs_flag);                     // R9
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rs_flag) |-> ($past(auto_set) || $past(expire)));               // R3
  AST_EXP_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (expire && !(frm_done && frm_suppr)) |=> !tmr_run);                   // R10
  AST_EXP_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |-> tmr_run);                                                  // R5
endmodule

bind rx_stat_wdog rsw_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .rd_data(rd_data), .cnt_q(cnt_q),
  .frm_done(frm_done), .frm_suppr(frm_suppr), .auto_set(auto_set),
  .flag_clr(flag_clr), .expire(expire), .tmr_run(tmr_run), .rs_flag(rs_flag)
);

// File: tb/sim_rx_stat_wdog.sv
module sim_rx_stat_wdog;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_LIMIT = 190000;

  logic        clk, rst_n, wr_en, frm_done, frm_suppr, auto_set, flag_clr;
  logic [7:0]  wr_count;
  logic [31:0] rd_data;
  logic        rs_flag;
  int n_chk, n_fail, cyc;
  bit done;

  rx_stat_wdog u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_count(wr_count),
    .rd_data(rd_data), .frm_done(frm_done), .frm_suppr(frm_suppr),
    .auto_set(auto_set), .flag_clr(flag_clr), .rs_flag(rs_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !done) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WDOG_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // drive one-cycle pulse; returns just after the edge that samples it
  task automatic pulse(input bit d, input bit s, input bit a, input bit c);
    @(negedge clk);
    frm_done = d; frm_suppr = s; auto_set = a; flag_clr = c;
    @(posedge clk);
    #1;
    @(negedge clk);
    frm_done = 0; frm_suppr = 0; auto_set = 0; flag_clr = 0;
  endtask

  task automatic write_cnt(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_count = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  // arm at edge E; returns at time E+1, counting further edges from E
  task automatic arm_at_edge();
    @(negedge clk);
    frm_done = 1; frm_suppr = 1;
    @(posedge clk);
    #1;
    frm_done = 0; frm_suppr = 0;
  endtask

  task automatic clear_flag();
    pulse(0, 0, 0, 1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 0;
    rst_n = 0; wr_en = 0; wr_count = 0;
    frm_done = 0; frm_suppr = 0; auto_set = 0; flag_clr = 0;
    #(CLK_PERIOD*3 + 2);
    rst_n = 1;
    edges(4);

    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 flag", {31'b0, rs_flag}, 32'h0);

    // R2 readback, reserved bits zero
    write_cnt(8'hA5);
    check("R2 rd_data A5", rd_data, 32'h0000_00A5);
    write_cnt(8'hFF);
    check("R2 rd_data FF", rd_data, 32'h0000_00FF);

    // R3 sweep of delay N*256, N in 1..8 and 255
    for (int i = 0; i < 9; i++) begin
      int n;
      n = (i < 8) ? i + 1 : 255;
      write_cnt(n[7:0]);
      arm_at_edge();
      edges(n*256 - 1);
      check($sformatf("R3 N=%0d before", n), {31'b0, rs_flag}, 32'h0);
      edges(1);
      check($sformatf("R3 N=%0d at", n), {31'b0, rs_flag}, 32'h1);
      clear_flag();
      check("R9 clear alone", {31'b0, rs_flag}, 32'h0);
      // R10 stopped after expiry
      edges(n < 4 ? n*256 + 20 : 40);
      check($sformatf("R10 N=%0d no re-set", n), {31'b0, rs_flag}, 32'h0);
    end

    // R4 zero count: arming ignored
    write_cnt(8'h00);
    arm_at_edge();
    edges(700);
    check("R4 zero count", {31'b0, rs_flag}, 32'h0);

    // R5 non-suppressed completion does not arm
    write_cnt(8'h01);
    pulse(1, 0, 0, 0);
    edges(600);
    check("R5 no arm", {31'b0, rs_flag}, 32'h0);

    // R6 auto set sets flag and cancels timer
    write_cnt(8'h02);
    arm_at_edge();
    edges(100);
    pulse(0, 0, 1, 0);
    check("R6 auto set", {31'b0, rs_flag}, 32'h1);
    clear_flag();
    edges(600);
    check("R6 cancelled", {31'b0, rs_flag}, 32'h0);

    // R7 re-arm restarts delay
    arm_at_edge();
    edges(300);
    arm_at_edge();
    edges(511);
    check("R7 before", {31'b0, rs_flag}, 32'h0);
    edges(1);
    check("R7 at", {31'b0, rs_flag}, 32'h1);
    clear_flag();

    // R8 write zero while running
    write_cnt(8'h03);
    arm_at_edge();
    edges(100);
    write_cnt(8'h00);
    write_cnt(8'h03);
    edges(900);
    check("R8 stopped", {31'b0, rs_flag}, 32'h0);

    // R9 hold without clear
    pulse(0, 0, 1, 0);
    edges(50);
    check("R9 hold", {31'b0, rs_flag}, 32'h1);
    // R9 clear same cycle as auto set
    pulse(0, 0, 1, 1);
    check("R9 clr vs auto", {31'b0, rs_flag}, 32'h1);
    // R9 clear same cycle as expiry
    write_cnt(8'h01);
    arm_at_edge();
    edges(255);
    @(negedge clk);
    flag_clr = 1;
    @(posedge clk);
    #1;
    check("R9 clr vs expiry", {31'b0, rs_flag}, 32'h1);
    @(negedge clk);
    flag_clr = 0;
    clear_flag();
    check("R9 clr after", {31'b0, rs_flag}, 32'h0);

    // R11 auto set and arm in same cycle
    pulse(1, 1, 1, 0);
    check("R11 flag set", {31'b0, rs_flag}, 32'h1);
    clear_flag();
    edges(600);
    check("R11 not armed", {31'b0, rs_flag}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule